// File: doc/BRIEF.md
# Cascaded CAM Chain Link

This block is the per-device glue that lets a string of identical content-addressable memories act as one deeper memory. Each device in the string carries one instance. The instance holds the device's page number, which becomes the upper part of every system-wide match address. It also holds a device-select value that picks one device, or all of them, for ordinary accesses.

The instance receives the active-low match and full flags rippled from the device above it, along with its own device's local flags. It passes on combined flags to the device below. From the same flags it decides whether its device drives read data or accepts a write. It does this per access kind:
- Accesses aimed at the highest-priority match go only to the first device in the string that matched.
- Accesses aimed at the next free location go only to the first device that still has room.
- Ordinary accesses go to every selected device.

If the last compare found no match anywhere in the string, reads are refused. The one exception is the next-free register.

Top module: `cam_chain_link`

## Requirements
- R1: After reset the page register holds zero and the select register holds all ones, so every device is selected.
- R2: A cycle with `page_we` high loads `cfg_data` into the page register, and a cycle with `sel_wr` high loads it into the select register; both take effect on the next clock edge.
- R3: A device is selected when its select register equals its page register, or when the select register is all ones.
- R4: `dn_match_n` is low exactly when `up_match_n` is low or `loc_match_n` is low.
- R5: `dn_full_n` is low exactly when both `up_full_n` and `loc_full_n` are low.
- R6: `sys_addr` equals the page register concatenated above `loc_addr` when the device matched locally and `up_match_n` is high. Otherwise `sys_addr` is zero.
- R7: `op_kind` codes are 2'b00 ordinary, 2'b01 at the highest-priority match, 2'b10 at the next free location, and 2'b11 the next-free register.
- R8: An ordinary read (kind 00) is driven only by a selected device, and only while `sys_match_n` is low.
- R9: A read or write of kind 01 is taken only by the device that matched locally with `up_match_n` high, whatever its select value.
- R10: A write of kind 10 is taken only by the device whose `loc_full_n` is high while `up_full_n` is low. A read of kind 10 additionally needs `sys_match_n` low.
- R11: A read of kind 11 is driven by the first device that is not full, even when `sys_match_n` is high.
- R12: Writes of kind 00 and 11 are accepted by every selected device, regardless of the match and full flags.
- R13: A device at the head of the string has `up_match_n` tied high and `up_full_n` tied low. It then owns highest-priority accesses whenever it matches, and next-free accesses whenever it is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_we | input | 1 | Load page register from `cfg_data` |
| sel_wr | input | 1 | Load select register from `cfg_data` |
| cfg_data | input | PAGE_W | Configuration write data |
| loc_match_n | input | 1 | Local device match flag, active low |
| loc_full_n | input | 1 | Local device full flag, active low |
| loc_addr | input | LOC_W | Local highest-priority match address |
| up_match_n | input | 1 | Match flag from the device above, active low |
| up_full_n | input | 1 | Full flag from the device above, active low |
| sys_match_n | input | 1 | System match flag from the string's tail, active low |
| op_rd | input | 1 | Read access in progress |
| op_wr | input | 1 | Write access in progress |
| op_kind | input | 2 | Access kind (see R7) |
| dn_match_n | output | 1 | Match flag to the device below, active low |
| dn_full_n | output | 1 | Full flag to the device below, active low |
| rd_drive | output | 1 | This device drives read data |
| wr_accept | output | 1 | This device accepts the write |
| sys_addr | output | PAGE_W+LOC_W | System match address, zero unless owner |

## Verification
The bench builds a string of four links with a 16-bit page and a 4-bit local address. With an all-ones select code of 16 bits, both individual and broadcast selection are reachable, as is a select value that names no device. Four devices are enough to put the match owner or the free-location owner at the head, in the middle or at the tail of the string, to have several matches at once, and to have every device full. The resolved system address is taken as the OR of all `sys_addr` outputs and compared against page and local address of the expected owner.

// File: rtl/cam_chain_link.sv
module cam_chain_link #(
  parameter int PAGE_W = 16,
  parameter int LOC_W  = 4,
  localparam int SYS_W = PAGE_W + LOC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_we,
  input  logic              sel_wr,
  input  logic [PAGE_W-1:0] cfg_data,
  input  logic              loc_match_n,
  input  logic              loc_full_n,
  input  logic [LOC_W-1:0]  loc_addr,
  input  logic              up_match_n,
  input  logic              up_full_n,
  input  logic              sys_match_n,
  input  logic              op_rd,
  input  logic              op_wr,
  input  logic [1:0]        op_kind,
  output logic              dn_match_n,
  output logic              dn_full_n,
  output logic              rd_drive,
  output logic              wr_accept,
  output logic [SYS_W-1:0]  sys_addr
);

  localparam logic [1:0] K_PLAIN = 2'b00;
  localparam logic [1:0] K_HIPRI = 2'b01;
  localparam logic [1:0] K_FREE  = 2'b10;
  localparam logic [1:0] K_FREG  = 2'b11;
  localparam logic [PAGE_W-1:0] ALL_DEV = '1;

  logic [PAGE_W-1:0] page_q, sel_q;
  logic selected, hp_own, nf_own;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      page_q <= '0;
      sel_q  <= ALL_DEV;
    end else begin
      if (page_we) page_q <= cfg_data;
      if (sel_wr)  sel_q  <= cfg_data;
    end

  assign selected   = (sel_q == page_q) || (sel_q == ALL_DEV);
  assign dn_match_n = up_match_n & loc_match_n;
  assign dn_full_n  = up_full_n | loc_full_n;
  assign hp_own     = !loc_match_n && up_match_n;
  assign nf_own     = loc_full_n && !up_full_n;
  assign sys_addr   = hp_own ? {page_q, loc_addr} : '0;

  always_comb begin
    rd_drive = 1'b0;
    unique case (op_kind)
      K_PLAIN: rd_drive = selected && !sys_match_n;
      K_HIPRI: rd_drive = hp_own;
      K_FREE:  rd_drive = nf_own && !sys_match_n;
      K_FREG:  rd_drive = nf_own;
    endcase
    rd_drive = rd_drive && op_rd;
  end

  always_comb begin
    wr_accept = 1'b0;
    unique case (op_kind)
      K_PLAIN, K_FREG: wr_accept = selected;
      K_HIPRI:         wr_accept = hp_own;
      K_FREE:          wr_accept = nf_own;
    endcase
    wr_accept = wr_accept && op_wr;
  end

  // R2
  page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_we |=> page_q == $past(cfg_data));

  // R2
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> sel_q == $past(cfg_data));

  // R8
  rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind != K_FREG && sys_match_n) |-> !rd_drive);

  // R9
  hp_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == K_HIPRI && !up_match_n) |-> !(rd_drive || wr_accept));

  // R10
  nf_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == K_FREE && up_full_n) |-> !(rd_drive || wr_accept));

  // R6
  addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_match_n || !up_match_n) |-> sys_addr == '0);

endmodule

// File: tb/test_cam_chain_link.sv
module test_cam_chain_link;
  localparam int N = 4;
  localparam int PW = 16;
  localparam int LW = 4;

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic [N-1:0] pwe = '0;
  logic swe = 0;
  logic [PW-1:0] cdat = '0;
  logic [N-1:0] lm = '0, lf = '0;
  logic [LW-1:0] la [N];
  logic ord = 0, owr = 0;
  logic [1:0] kind = 2'b00;

  logic [N:0] mch, fch;
  logic [N-1:0] rd, wa;
  logic [PW+LW-1:0] ad [N];
  logic [PW+LW-1:0] addr_or;

  assign mch[0] = 1'b1;
  assign fch[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : gen_dev
    cam_chain_link #(.PAGE_W(PW), .LOC_W(LW)) i_cam_chain_link (
      .clk(clk), .rst_n(rst_n), .page_we(pwe[g]), .sel_wr(swe), .cfg_data(cdat),
      .loc_match_n(~lm[g]), .loc_full_n(~lf[g]), .loc_addr(la[g]),
      .up_match_n(mch[g]), .up_full_n(fch[g]), .sys_match_n(mch[N]),
      .op_rd(ord), .op_wr(owr), .op_kind(kind),
      .dn_match_n(mch[g+1]), .dn_full_n(fch[g+1]),
      .rd_drive(rd[g]), .wr_accept(wa[g]), .sys_addr(ad[g]));
  end

  always_comb begin
    addr_or = '0;
    for (int i = 0; i < N; i++) addr_or = addr_or | ad[i];
  end

  int total = 0, bad = 0;
  bit done = 0;
  logic [PW-1:0] pages [N];
  logic [PW-1:0] sel_sh;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int first_one(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [N-1:0] sel_vec();
    logic [N-1:0] s;
    for (int i = 0; i < N; i++) s[i] = (sel_sh == pages[i]) || (sel_sh == '1);
    return s;
  endfunction

  task automatic set_page(int i, logic [PW-1:0] v);
    @(negedge clk); pwe[i] = 1; cdat = v;
    @(negedge clk); pwe[i] = 0;
    pages[i] = v;
  endtask

  task automatic set_sel(logic [PW-1:0] v);
    @(negedge clk); swe = 1; cdat = v;
    @(negedge clk); swe = 0;
    sel_sh = v;
  endtask

  task automatic run_ops(string req);
    int hp, nf;
    logic any;
    logic [N-1:0] s, oh_hp, oh_nf, er, ew;
    hp = first_one(lm);
    nf = first_one(~lf);
    any = |lm;
    s = sel_vec();
    oh_hp = '0; oh_nf = '0;
    if (hp >= 0) oh_hp[hp] = 1'b1;
    if (nf >= 0) oh_nf[nf] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      case (k)
        0: begin er = any ? s : '0;     ew = s;     end
        1: begin er = oh_hp;            ew = oh_hp; end
        2: begin er = any ? oh_nf : '0; ew = oh_nf; end
        default: begin er = oh_nf;      ew = s;     end
      endcase
      @(negedge clk); kind = k[1:0]; ord = 1; owr = 0;
      #2 chk({req, " R7 rd"}, 32'(rd), 32'(er));
      @(negedge clk); ord = 0; owr = 1;
      #2 chk({req, " R7 wr"}, 32'(wa), 32'(ew));
    end
    @(negedge clk); owr = 0;
    #2;
    chk({req, " R4 sysmatch"}, 32'(mch[N]), 32'(!any));
    chk({req, " R5 sysfull"}, 32'(fch[N]), 32'(!(&lf)));
    chk({req, " R6 addr"}, 32'(addr_or),
        hp >= 0 ? 32'({pages[hp], la[hp]}) : 32'h0);
  endtask

  task automatic t_reset();
    lm = '0; lf = '0;
    @(negedge clk); kind = 2'b00; owr = 1;
    #2 chk("R1 all selected after reset", 32'(wa), 32'hF);
    @(negedge clk); owr = 0;
    lm = 4'b0100; la[2] = 4'h9;
    #2 chk("R1 page zero after reset", 32'(addr_or), 32'h9);
    lm = '0;
  endtask

  task automatic t_config();
    for (int i = 0; i < N; i++) set_page(i, 16'h0A10 + 16'(i));
    set_sel(16'h0A12);
    lm = 4'b0001; lf = '0;
    run_ops("R2 R3 single select");
    set_sel(16'h0777);
    run_ops("R3 no device selected");
    set_sel(16'hFFFF);
    run_ops("R12 broadcast");
  endtask

  task automatic t_match();
    lm = 4'b1010; lf = 4'b0000;
    run_ops("R9 two matches");
    lm = 4'b1000;
    run_ops("R9 tail match");
    lm = 4'b1111;
    run_ops("R13 head match");
  endtask

  task automatic t_nomatch();
    lm = '0; lf = 4'b0011;
    set_sel(16'h0A13);
    run_ops("R8 R11 no match");
  endtask

  task automatic t_free();
    set_sel(16'hFFFF);
    lm = 4'b0100; lf = 4'b0111;
    run_ops("R10 free at tail");
    lf = 4'b0101;
    run_ops("R10 free in middle");
    lf = 4'b1111;
    run_ops("R5 all full");
    lf = 4'b1110;
    run_ops("R13 head free");
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin la[i] = 4'(3 * i + 1); pages[i] = '0; end
    sel_sh = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_config();
    t_match();
    t_nomatch();
    t_free();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule